// File: doc/BRIEF.md
# DDS Modulation Source Priority Selector

This block chooses what drives the frequency, phase and amplitude controls of a direct digital synthesizer. Four modulation engines can be switched on at the same time: a waveform RAM, a digital ramp generator, a parallel data port and an on-off shaping keyer. Each engine except the keyer names a destination with a 2-bit code. For each control word the block applies its own fixed ranking and lets only the best eligible engine through. When no engine claims a word, the block uses a programmed register or the active single-tone profile instead.

The engines are outside this block. Their data arrives as plain input buses, and the programmed registers and active-profile fields arrive the same way. The block registers the three control words, an amplitude-scaling-enable flag and a 3-bit code per word that tells which source won.

Top module: `dds_src_prio`

## Requirements
- R1: Frequency ranking: RAM with destination 00 gives `ram_data`. Otherwise the ramp with destination 00 gives `ramp_data`. Otherwise the parallel port with destination 00 gives `ftw_reg` + `par_data` (zero-extended), modulo 2^32.
- R2: When no source claims frequency, `freq_word` is `ftw_reg` if the RAM is enabled and `prof_ftw` otherwise.
- R3: Phase ranking:
  - RAM with destination 01 or 11 gives `ram_data[31:16]`.
  - Otherwise the ramp with destination 01 gives `ramp_data[31:16]`.
  - Otherwise the parallel port with destination 01 gives `par_data`.
  - Otherwise the parallel port with destination 11 gives {`par_data[15:8]`, `pow_reg[7:0]`}.
- R4: When no source claims phase, `phase_word` is `pow_reg` if the RAM is enabled and `prof_pow` otherwise.
- R5: Amplitude ranking:
  - Keyer enabled in automatic mode gives `key_amp`.
  - Otherwise the keyer enabled in manual mode gives `asf_reg`.
  - Otherwise RAM with destination 10 or 11 gives `ram_data[31:18]`.
  - Otherwise the ramp with destination 10 gives `ramp_data[31:18]`.
  - Otherwise the parallel port with destination 10 gives `par_data[15:2]`.
- R6: Below those, the parallel port with destination 11 gives {`par_data[7:0]`, `asf_reg[5:0]`}. Next, `prof_scale_en` set gives `prof_asf`. Otherwise `amp_word` is 0 and `amp_scale_en` is 0; in every other case `amp_scale_en` is 1.
- R7: Destination codes are 00 frequency, 01 phase, 10 amplitude and 11 polar. A ramp destination of 11 claims no word.
- R8: Each source code output is 0 none, 1 profile, 2 register (including manual keyer), 3 RAM, 4 ramp, 5 parallel, 6 polar parallel or 7 automatic keyer.
- R9: All outputs are registered and reflect the inputs present at the previous rising clock edge.
- R10: An asynchronous active-low reset clears all words and codes to 0 and `amp_scale_en` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ram_en | input | 1 | Waveform RAM enable |
| ram_dest | input | 2 | RAM destination code |
| ram_data | input | 32 | RAM output data |
| ramp_en | input | 1 | Ramp generator enable |
| ramp_dest | input | 2 | Ramp destination code |
| ramp_data | input | 32 | Ramp generator data |
| par_en | input | 1 | Parallel port enable |
| par_dest | input | 2 | Parallel port destination code |
| par_data | input | 16 | Parallel port word |
| key_en | input | 1 | Shaping keyer enable |
| key_auto | input | 1 | Keyer automatic (1) or manual (0) mode |
| key_amp | input | 14 | Keyer generated amplitude |
| ftw_reg | input | 32 | Programmed frequency tuning register |
| pow_reg | input | 16 | Programmed phase offset register |
| asf_reg | input | 14 | Programmed amplitude scale register |
| prof_ftw | input | 32 | Active profile tuning word |
| prof_pow | input | 16 | Active profile phase offset |
| prof_asf | input | 14 | Active profile amplitude scale |
| prof_scale_en | input | 1 | Use profile amplitude scale as fallback |
| freq_word | output | 32 | Selected frequency word |
| phase_word | output | 16 | Selected phase word |
| amp_word | output | 14 | Selected amplitude word |
| amp_scale_en | output | 1 | Amplitude scaling active |
| freq_src | output | 3 | Winning frequency source code |
| phase_src | output | 3 | Winning phase source code |
| amp_src | output | 3 | Winning amplitude source code |

## Verification
Every result is due exactly one rising edge after its inputs are present. The bench therefore drives on the falling edge and compares on the following falling edge, by which time one rising edge has captured the new values. A latency check samples the outputs once just after new inputs are driven, where they must still show the old result, and again one edge later. Reset is asserted between edges and its effect is checked at once, because no clock edge is involved.

// File: rtl/dds_src_pkg.sv
package dds_src_pkg;
  localparam logic [1:0] DEST_FREQ  = 2'b00;
  localparam logic [1:0] DEST_PHASE = 2'b01;
  localparam logic [1:0] DEST_AMPL  = 2'b10;
  localparam logic [1:0] DEST_POLAR = 2'b11;

  typedef enum logic [2:0] {
    SRC_NONE    = 3'd0,
    SRC_PROFILE = 3'd1,
    SRC_REG     = 3'd2,
    SRC_RAM     = 3'd3,
    SRC_RAMP    = 3'd4,
    SRC_PAR     = 3'd5,
    SRC_POLAR   = 3'd6,
    SRC_KEYER   = 3'd7
  } src_e;
endpackage

// File: rtl/dds_freq_pick.sv
module dds_freq_pick
  import dds_src_pkg::*;
#(
  parameter int FW = 32,
  parameter int PW = 16
) (
  input  logic          ram_en,
  input  logic [1:0]    ram_dest,
  input  logic [FW-1:0] ram_data,
  input  logic          ramp_en,
  input  logic [1:0]    ramp_dest,
  input  logic [FW-1:0] ramp_data,
  input  logic          par_en,
  input  logic [1:0]    par_dest,
  input  logic [PW-1:0] par_data,
  input  logic [FW-1:0] ftw_reg,
  input  logic [FW-1:0] prof_ftw,
  output logic [FW-1:0] word,
  output src_e          src
);
  localparam int PAD = FW - PW;
  logic [FW-1:0] par_sum;

  assign par_sum = ftw_reg + {{PAD{1'b0}}, par_data};

  always_comb begin
    word = prof_ftw;
    src  = SRC_PROFILE;
    if (ram_en && ram_dest == DEST_FREQ) begin
      word = ram_data;
      src  = SRC_RAM;
    end else if (ramp_en && ramp_dest == DEST_FREQ) begin
      word = ramp_data;
      src  = SRC_RAMP;
    end else if (par_en && par_dest == DEST_FREQ) begin
      word = par_sum;
      src  = SRC_PAR;
    end else if (ram_en) begin
      word = ftw_reg;
      src  = SRC_REG;
    end
  end
endmodule

// File: rtl/dds_phase_pick.sv
module dds_phase_pick
  import dds_src_pkg::*;
#(
  parameter int FW  = 32,
  parameter int PW  = 16,
  parameter int PHW = 16
) (
  input  logic           ram_en,
  input  logic [1:0]     ram_dest,
  input  logic [FW-1:0]  ram_data,
  input  logic           ramp_en,
  input  logic [1:0]     ramp_dest,
  input  logic [FW-1:0]  ramp_data,
  input  logic           par_en,
  input  logic [1:0]     par_dest,
  input  logic [PW-1:0]  par_data,
  input  logic [PHW-1:0] pow_reg,
  input  logic [PHW-1:0] prof_pow,
  output logic [PHW-1:0] word,
  output src_e           src
);
  localparam int HALF = PW / 2;
  localparam int KEEP = PHW - HALF;

  always_comb begin
    word = prof_pow;
    src  = SRC_PROFILE;
    if (ram_en && (ram_dest == DEST_PHASE || ram_dest == DEST_POLAR)) begin
      word = ram_data[FW-1 -: PHW];
      src  = SRC_RAM;
    end else if (ramp_en && ramp_dest == DEST_PHASE) begin
      word = ramp_data[FW-1 -: PHW];
      src  = SRC_RAMP;
    end else if (par_en && par_dest == DEST_PHASE) begin
      word = par_data;
      src  = SRC_PAR;
    end else if (par_en && par_dest == DEST_POLAR) begin
      word = {par_data[PW-1 -: HALF], pow_reg[KEEP-1:0]};
      src  = SRC_POLAR;
    end else if (ram_en) begin
      word = pow_reg;
      src  = SRC_REG;
    end
  end
endmodule

// File: rtl/dds_amp_pick.sv
module dds_amp_pick
  import dds_src_pkg::*;
#(
  parameter int FW = 32,
  parameter int PW = 16,
  parameter int AW = 14
) (
  input  logic          ram_en,
  input  logic [1:0]    ram_dest,
  input  logic [FW-1:0] ram_data,
  input  logic          ramp_en,
  input  logic [1:0]    ramp_dest,
  input  logic [FW-1:0] ramp_data,
  input  logic          par_en,
  input  logic [1:0]    par_dest,
  input  logic [PW-1:0] par_data,
  input  logic          key_en,
  input  logic          key_auto,
  input  logic [AW-1:0] key_amp,
  input  logic [AW-1:0] asf_reg,
  input  logic [AW-1:0] prof_asf,
  input  logic          prof_scale_en,
  output logic [AW-1:0] word,
  output src_e          src
);
  localparam int HALF = PW / 2;
  localparam int KEEP = AW - HALF;

  always_comb begin
    word = '0;
    src  = SRC_NONE;
    if (key_en && key_auto) begin
      word = key_amp;
      src  = SRC_KEYER;
    end else if (key_en) begin
      word = asf_reg;
      src  = SRC_REG;
    end else if (ram_en && (ram_dest == DEST_AMPL || ram_dest == DEST_POLAR)) begin
      word = ram_data[FW-1 -: AW];
      src  = SRC_RAM;
    end else if (ramp_en && ramp_dest == DEST_AMPL) begin
      word = ramp_data[FW-1 -: AW];
      src  = SRC_RAMP;
    end else if (par_en && par_dest == DEST_AMPL) begin
      word = par_data[PW-1 -: AW];
      src  = SRC_PAR;
    end else if (par_en && par_dest == DEST_POLAR) begin
      word = {par_data[HALF-1:0], asf_reg[KEEP-1:0]};
      src  = SRC_POLAR;
    end else if (prof_scale_en) begin
      word = prof_asf;
      src  = SRC_PROFILE;
    end
  end
endmodule

// File: rtl/dds_src_prio.sv
module dds_src_prio
  import dds_src_pkg::*;
#(
  parameter int FW  = 32,
  parameter int PW  = 16,
  parameter int PHW = 16,
  parameter int AW  = 14
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ram_en,
  input  logic [1:0]     ram_dest,
  input  logic [FW-1:0]  ram_data,
  input  logic           ramp_en,
  input  logic [1:0]     ramp_dest,
  input  logic [FW-1:0]  ramp_data,
  input  logic           par_en,
  input  logic [1:0]     par_dest,
  input  logic [PW-1:0]  par_data,
  input  logic           key_en,
  input  logic           key_auto,
  input  logic [AW-1:0]  key_amp,
  input  logic [FW-1:0]  ftw_reg,
  input  logic [PHW-1:0] pow_reg,
  input  logic [AW-1:0]  asf_reg,
  input  logic [FW-1:0]  prof_ftw,
  input  logic [PHW-1:0] prof_pow,
  input  logic [AW-1:0]  prof_asf,
  input  logic           prof_scale_en,
  output logic [FW-1:0]  freq_word,
  output logic [PHW-1:0] phase_word,
  output logic [AW-1:0]  amp_word,
  output logic           amp_scale_en,
  output logic [2:0]     freq_src,
  output logic [2:0]     phase_src,
  output logic [2:0]     amp_src
);
  localparam int BUS_W = FW + PHW + AW + 1 + 9;

  logic [FW-1:0]  f_nxt;
  logic [PHW-1:0] p_nxt;
  logic [AW-1:0]  a_nxt;
  src_e           fs_nxt, ps_nxt, as_nxt;
  logic           sc_nxt;
  logic [BUS_W-1:0] nxt_bus, cur_bus;
  logic           upd_en;
  logic           armed_q;

  dds_freq_pick #(.FW(FW), .PW(PW)) u_freq (
    .ram_en(ram_en), .ram_dest(ram_dest), .ram_data(ram_data),
    .ramp_en(ramp_en), .ramp_dest(ramp_dest), .ramp_data(ramp_data),
    .par_en(par_en), .par_dest(par_dest), .par_data(par_data),
    .ftw_reg(ftw_reg), .prof_ftw(prof_ftw),
    .word(f_nxt), .src(fs_nxt)
  );

  dds_phase_pick #(.FW(FW), .PW(PW), .PHW(PHW)) u_phase (
    .ram_en(ram_en), .ram_dest(ram_dest), .ram_data(ram_data),
    .ramp_en(ramp_en), .ramp_dest(ramp_dest), .ramp_data(ramp_data),
    .par_en(par_en), .par_dest(par_dest), .par_data(par_data),
    .pow_reg(pow_reg), .prof_pow(prof_pow),
    .word(p_nxt), .src(ps_nxt)
  );

  dds_amp_pick #(.FW(FW), .PW(PW), .AW(AW)) u_amp (
    .ram_en(ram_en), .ram_dest(ram_dest), .ram_data(ram_data),
    .ramp_en(ramp_en), .ramp_dest(ramp_dest), .ramp_data(ramp_data),
    .par_en(par_en), .par_dest(par_dest), .par_data(par_data),
    .key_en(key_en), .key_auto(key_auto), .key_amp(key_amp),
    .asf_reg(asf_reg), .prof_asf(prof_asf), .prof_scale_en(prof_scale_en),
    .word(a_nxt), .src(as_nxt)
  );

  // next-state: scaling is active unless the amplitude chain fell through
  always_comb begin
    sc_nxt  = (as_nxt != SRC_NONE);
    nxt_bus = {f_nxt, p_nxt, a_nxt, sc_nxt, fs_nxt, ps_nxt, as_nxt};
    cur_bus = {freq_word, phase_word, amp_word, amp_scale_en,
               freq_src, phase_src, amp_src};
    upd_en  = (nxt_bus != cur_bus);
  end

  // register process with explicit clock enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      freq_word    <= '0;
      phase_word   <= '0;
      amp_word     <= '0;
      amp_scale_en <= 1'b0;
      freq_src     <= 3'd0;
      phase_src    <= 3'd0;
      amp_src      <= 3'd0;
    end else if (upd_en) begin
      freq_word    <= f_nxt;
      phase_word   <= p_nxt;
      amp_word     <= a_nxt;
      amp_scale_en <= sc_nxt;
      freq_src     <= fs_nxt;
      phase_src    <= ps_nxt;
      amp_src      <= as_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= 1'b1;
  end

  // R1: RAM aimed at frequency always wins the frequency word
  a_r1_ram_freq_wins: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q && $past(ram_en && ram_dest == DEST_FREQ)
    |-> (freq_src == SRC_RAM) && (freq_word == $past(ram_data)));

  // R5: automatic keyer overrides every other amplitude source
  a_r5_keyer_auto_wins: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q && $past(key_en && key_auto)
    |-> (amp_src == SRC_KEYER) && (amp_word == $past(key_amp)) && amp_scale_en);

  // R6: scaling off means a zero amplitude with no winning source
  a_r6_scale_off_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !amp_scale_en |-> (amp_word == '0) && (amp_src == 3'd0));

  // R7: ramp with the polar code alone claims nothing
  a_r7_ramp_polar_idle: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q && $past(ramp_en && ramp_dest == DEST_POLAR && !ram_en && !par_en && !key_en)
    |-> (freq_src == SRC_PROFILE) && (phase_src == SRC_PROFILE)
        && (amp_src != SRC_RAMP));

  // R9: outputs hold when the previous-edge inputs were unchanged
  a_r9_hold_when_stable: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q && $past(armed_q) && $stable(freq_word) && $past(ram_en && ram_dest == DEST_FREQ)
    && $stable(ram_data) |-> $stable(freq_src));
endmodule

// File: tb/sim_dds_src_prio.sv
module sim_dds_src_prio;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ram_en, ramp_en, par_en, key_en, key_auto, prof_scale_en;
  logic [1:0]  ram_dest, ramp_dest, par_dest;
  logic [31:0] ram_data, ramp_data, ftw_reg, prof_ftw;
  logic [15:0] par_data, pow_reg, prof_pow;
  logic [13:0] key_amp, asf_reg, prof_asf;
  logic [31:0] freq_word;
  logic [15:0] phase_word;
  logic [13:0] amp_word;
  logic        amp_scale_en;
  logic [2:0]  freq_src, phase_src, amp_src;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  dds_src_prio u0 (
    .clk(clk), .rst_n(rst_n),
    .ram_en(ram_en), .ram_dest(ram_dest), .ram_data(ram_data),
    .ramp_en(ramp_en), .ramp_dest(ramp_dest), .ramp_data(ramp_data),
    .par_en(par_en), .par_dest(par_dest), .par_data(par_data),
    .key_en(key_en), .key_auto(key_auto), .key_amp(key_amp),
    .ftw_reg(ftw_reg), .pow_reg(pow_reg), .asf_reg(asf_reg),
    .prof_ftw(prof_ftw), .prof_pow(prof_pow), .prof_asf(prof_asf),
    .prof_scale_en(prof_scale_en),
    .freq_word(freq_word), .phase_word(phase_word), .amp_word(amp_word),
    .amp_scale_en(amp_scale_en),
    .freq_src(freq_src), .phase_src(phase_src), .amp_src(amp_src)
  );

  typedef struct packed {
    logic [31:0] f;
    logic [15:0] p;
    logic [13:0] a;
    logic        s;
    logic [2:0]  fs, ps, as_;
  } exp_t;

  // independent reference ranking, written as lookup of first eligible entry
  function automatic exp_t ref_calc();
    exp_t e;
    bit ram_ph  = ram_en  && (ram_dest == 2'd1 || ram_dest == 2'd3);
    bit ram_am  = ram_en  && (ram_dest == 2'd2 || ram_dest == 2'd3);
    e = '0;
    // frequency (R1, R2)
    case (1'b1)
      (ram_en  && ram_dest  == 2'd0): begin e.f = ram_data;  e.fs = 3; end
      (ramp_en && ramp_dest == 2'd0): begin e.f = ramp_data; e.fs = 4; end
      (par_en  && par_dest  == 2'd0): begin e.f = ftw_reg + 32'(par_data); e.fs = 5; end
      ram_en:                         begin e.f = ftw_reg;   e.fs = 2; end
      default:                        begin e.f = prof_ftw;  e.fs = 1; end
    endcase
    // phase (R3, R4)
    case (1'b1)
      ram_ph:                         begin e.p = ram_data[31:16];  e.ps = 3; end
      (ramp_en && ramp_dest == 2'd1): begin e.p = ramp_data[31:16]; e.ps = 4; end
      (par_en  && par_dest  == 2'd1): begin e.p = par_data;         e.ps = 5; end
      (par_en  && par_dest  == 2'd3): begin e.p = {par_data[15:8], pow_reg[7:0]}; e.ps = 6; end
      ram_en:                         begin e.p = pow_reg;  e.ps = 2; end
      default:                        begin e.p = prof_pow; e.ps = 1; end
    endcase
    // amplitude (R5, R6)
    case (1'b1)
      (key_en && key_auto):           begin e.a = key_amp;          e.as_ = 7; end
      key_en:                         begin e.a = asf_reg;          e.as_ = 2; end
      ram_am:                         begin e.a = ram_data[31:18];  e.as_ = 3; end
      (ramp_en && ramp_dest == 2'd2): begin e.a = ramp_data[31:18]; e.as_ = 4; end
      (par_en  && par_dest  == 2'd2): begin e.a = par_data[15:2];   e.as_ = 5; end
      (par_en  && par_dest  == 2'd3): begin e.a = {par_data[7:0], asf_reg[5:0]}; e.as_ = 6; end
      prof_scale_en:                  begin e.a = prof_asf; e.as_ = 1; end
      default:                        begin e.a = '0;       e.as_ = 0; end
    endcase
    e.s = (e.as_ != 0);
    return e;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp_v);
    n_chk++;
    if (act !== exp_v) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp_v);
    end
  endtask

  task automatic chk_all(input exp_t e);
    chk("R1 R2 freq_word", 64'(freq_word), 64'(e.f));
    chk("R3 R4 phase_word", 64'(phase_word), 64'(e.p));
    chk("R5 R6 amp_word+scale", 64'({amp_word, amp_scale_en}), 64'({e.a, e.s}));
    chk("R8 src codes", 64'({freq_src, phase_src, amp_src}), 64'({e.fs, e.ps, e.as_}));
  endtask

  // directed table: {ram_en,ram_dest,ramp_en,ramp_dest,par_en,par_dest,
  //                  key_en,key_auto,prof_scale_en, fsrc,psrc,asrc}
  localparam logic [20:0] TBL [4] = '{
    21'b0_00_0_00_0_00_0_0_0_001_001_000,
    21'b1_00_0_00_1_00_0_0_0_011_010_000,
    21'b0_00_1_11_1_11_0_0_1_001_110_110,
    21'b1_10_1_01_0_00_1_0_0_010_100_010
  };

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : stim
    exp_t e;
    rst_n = 1'b0;
    {ram_en, ramp_en, par_en, key_en, key_auto, prof_scale_en} = '0;
    {ram_dest, ramp_dest, par_dest} = '0;
    ram_data  = 32'hA1B2_C3D4; ramp_data = 32'h5E6F_7081;
    par_data  = 16'h9C3A;      key_amp   = 14'h2BCD;
    ftw_reg   = 32'hFFFF_FF00; pow_reg   = 16'h4DA7; asf_reg = 14'h1E5B;
    prof_ftw  = 32'h1357_9BDF; prof_pow  = 16'h2468; prof_asf = 14'h0F0F;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 reset outputs", 64'({freq_word, phase_word, amp_word, amp_scale_en}), 64'd0);
    chk("R10 reset codes", 64'({freq_src, phase_src, amp_src}), 64'd0);
    rst_n = 1'b1;

    // directed table walk (R8, R7)
    foreach (TBL[i]) begin
      {ram_en, ram_dest, ramp_en, ramp_dest, par_en, par_dest,
       key_en, key_auto, prof_scale_en} = TBL[i][20:9];
      @(negedge clk);
      chk("R8 R7 table codes", 64'({freq_src, phase_src, amp_src}), 64'(TBL[i][8:0]));
    end

    // exhaustive sweep against the reference (R1..R8)
    for (int m = 0; m < 4096; m++) begin
      {ram_en, ram_dest, ramp_en, ramp_dest, par_en, par_dest,
       key_en, key_auto, prof_scale_en} = 12'(m);
      par_data = 16'h9C3A ^ 16'(m * 7);
      e = ref_calc();
      @(negedge clk);
      chk_all(e);
    end

    // R1: parallel-port frequency sum wraps modulo 2^32
    {ram_en, ramp_en, key_en} = '0;
    par_en = 1'b1; par_dest = 2'd0; par_data = 16'h0234; ftw_reg = 32'hFFFF_FF00;
    @(negedge clk);
    chk("R1 wrap sum", 64'(freq_word), 64'h0000_0134);

    // R9: one edge of latency
    par_dest = 2'd1; par_data = 16'h7E11;
    #1;
    chk("R9 old value held before edge", 64'(phase_src), 64'd1);
    @(negedge clk);
    chk("R9 new value after one edge", 64'({phase_src, phase_word}), 64'({3'd5, 16'h7E11}));

    // R7: ramp polar code ignored, observed on all three words
    par_en = 1'b0; ramp_en = 1'b1; ramp_dest = 2'd3; prof_scale_en = 1'b0;
    @(negedge clk);
    chk("R7 ramp code 11 claims nothing",
        64'({freq_src, phase_src, amp_src, amp_scale_en}), 64'({3'd1, 3'd1, 3'd0, 1'b0}));

    // R10: asynchronous reset between edges
    key_en = 1'b1; key_auto = 1'b1;
    @(negedge clk);
    #2 rst_n = 1'b0;
    #1;
    chk("R10 async clear", 64'({amp_word, amp_scale_en, amp_src}), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R5 keyer after reset", 64'({amp_word, amp_src}), 64'({14'h2BCD, 3'd7}));

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule